// File: doc/BRIEF.md
# Multi-beat burst tracker

This block watches one valid/ready channel of a five-channel coherent cache link and follows each message through its data beats. For every message it first decides, from the channel kind and the opcode, whether the message carries a payload. It then derives how many beats the burst takes from the log2 byte-size field and the beat width. A remaining-beat counter follows the handshakes. Downstream logic uses the outputs to lock an arbiter for the whole burst and to step an address one beat at a time.

The beat count comes from a mask of `size` low-order ones, which equals the byte count minus one. This mask is shifted right by log2 of the beat width in bytes, which gives the number of beats minus one. A message without payload is always one beat. The kind, opcode and size are only looked at on the first beat. After that, the counter alone tracks the burst, so the fields may change freely until the burst ends.

Top module: `burst_beat_tracker`

## Requirements
- R1: After reset, `first` is 1, `done` is 0 and `beat_idx` is 0.
- R2: Channel kind codes are A=0, B=1, C=2, D=3, E=4. On kinds A and B a message carries data exactly when opcode bit 2 is 0.
- R3: On kinds C and D a message carries data exactly when opcode bit 0 is 1.
- R4: A message on kind E, on an unused kind code (5 to 7), or without data is one beat, whatever its size field.
- R5: A data message spans max(1, 2^size / BEAT_BYTES) beats. `first` is 1 exactly when no burst is in progress.
- R6: `last` is 1 while the beat now on the channel is the final beat of its message.
- R7: `done` is 1 only in a cycle where valid and ready are both 1 on the final beat. The cycle after `done` has `first` = 1.
- R8: `beat_idx` is 0 on the first beat. It rises by one on each accepted non-final beat and returns to 0 after the final beat.
- R9: A cycle without a handshake (valid or ready low) does not change the burst position.
- R10: During a burst, changes on kind, opcode and size have no effect on the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_kind | input | 3 | Channel kind code of the monitored channel |
| opcode | input | 3 | Message opcode |
| size | input | SIZE_W | log2 of the message size in bytes |
| valid | input | 1 | Channel valid |
| ready | input | 1 | Channel ready |
| first | output | 1 | Current beat opens a message |
| last | output | 1 | Current beat closes a message |
| done | output | 1 | Final beat accepted this cycle |
| beat_idx | output | CNT_W | Zero-based beat number within the message |

## Verification
The embedded properties check on every cycle how the counter moves over time. A completed message returns the tracker to idle. A stalled cycle leaves the position frozen. An accepted non-final beat leaves a burst open, and the index stays zero while idle. Only the bench scenarios can show that the beat counts are right: the data decision for each channel kind, the size-to-beats arithmetic at the edges (sizes below one beat, single-beat data), and that field changes in the middle of a burst are ignored. For these the bench compares against a behavioural model on every clock.

// File: rtl/bbt_pkg.sv
package bbt_pkg;
   typedef enum logic [2:0] {
      KIND_A = 3'd0,
      KIND_B = 3'd1,
      KIND_C = 3'd2,
      KIND_D = 3'd3,
      KIND_E = 3'd4
   } chan_kind_e;

   function automatic int clog2_i(input int v);
      int r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/bbt_payload_probe.sv
module bbt_payload_probe
   import bbt_pkg::*;
(
   input  logic [2:0] chan_kind,
   input  logic [2:0] opcode,
   output logic       has_payload
);
   logic unused_op_bit;
   assign unused_op_bit = opcode[1];

   always_comb begin
      case (chan_kind)
         KIND_A, KIND_B: has_payload = ~opcode[2];
         KIND_C, KIND_D: has_payload = opcode[0];
         default:        has_payload = 1'b0;
      endcase
   end
endmodule

// File: rtl/bbt_beat_len.sv
module bbt_beat_len #(
   parameter int SIZE_W     = 4,
   parameter int BEAT_BYTES = 8,
   localparam int MASK_W    = (1 << SIZE_W) - 1,
   localparam int SHIFT     = bbt_pkg::clog2_i(BEAT_BYTES),
   localparam int CNT_W     = MASK_W - SHIFT
) (
   input  logic [SIZE_W-1:0] size,
   input  logic              has_payload,
   output logic [CNT_W-1:0]  beats_m1
);
   logic [MASK_W-1:0] byte_mask;
   logic [CNT_W-1:0]  scaled;

   // ones below bit 'size': byte count minus one
   assign byte_mask = ~({MASK_W{1'b1}} << size);

   generate
      if (SHIFT == 0) begin : g_byte_beat
         assign scaled = byte_mask;
      end else begin : g_wide_beat
         logic [SHIFT-1:0] unused_low_bytes;
         assign unused_low_bytes = byte_mask[SHIFT-1:0];
         assign scaled = byte_mask[MASK_W-1:SHIFT];
      end
   endgenerate

   assign beats_m1 = has_payload ? scaled : '0;
endmodule

// File: rtl/bbt_beat_counter.sv
module bbt_beat_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             ready,
   input  logic [CNT_W-1:0] beats_m1,
   output logic             first,
   output logic             last,
   output logic             done,
   output logic [CNT_W-1:0] beat_idx
);
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] idx_q;
   logic             fire;

   assign fire     = valid & ready;
   assign first    = (rem_q == '0);
   assign last     = first ? (beats_m1 == '0) : (rem_q == CNT_W'(1));
   assign done     = fire & last;
   assign beat_idx = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         idx_q <= '0;
      end else if (fire) begin
         rem_q <= first ? beats_m1 : rem_q - CNT_W'(1);
         idx_q <= last ? '0 : idx_q + CNT_W'(1);
      end
   end

   // R7
   done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> first);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!first && !(valid && ready)) |=> ($stable(rem_q) && $stable(idx_q)));

   // R8
   idle_index_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      first |-> (idx_q == '0));

   // R5
   open_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready && !last) |=> !first);
endmodule

// File: rtl/burst_beat_tracker.sv
module burst_beat_tracker #(
   parameter int SIZE_W     = 4,
   parameter int BEAT_BYTES = 8,
   localparam int MASK_W    = (1 << SIZE_W) - 1,
   localparam int SHIFT     = bbt_pkg::clog2_i(BEAT_BYTES),
   localparam int CNT_W     = MASK_W - SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        chan_kind,
   input  logic [2:0]        opcode,
   input  logic [SIZE_W-1:0] size,
   input  logic              valid,
   input  logic              ready,
   output logic              first,
   output logic              last,
   output logic              done,
   output logic [CNT_W-1:0]  beat_idx
);
   initial begin
      beat_pow2_chk: assert ((1 << SHIFT) == BEAT_BYTES)
         else $error("BEAT_BYTES must be a power of two");
      width_fit_chk: assert (CNT_W >= 1)
         else $error("size range too small for the beat width");
   end

   logic             has_payload;
   logic [CNT_W-1:0] beats_m1;

   bbt_payload_probe u_probe (
      .chan_kind   (chan_kind),
      .opcode      (opcode),
      .has_payload (has_payload)
   );

   bbt_beat_len #(
      .SIZE_W     (SIZE_W),
      .BEAT_BYTES (BEAT_BYTES)
   ) u_len (
      .size        (size),
      .has_payload (has_payload),
      .beats_m1    (beats_m1)
   );

   bbt_beat_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (valid),
      .ready    (ready),
      .beats_m1 (beats_m1),
      .first    (first),
      .last     (last),
      .done     (done),
      .beat_idx (beat_idx)
   );
endmodule

// File: tb/sim_burst_beat_tracker.sv
`timescale 1ns/1ps
module sim_burst_beat_tracker;
   localparam int SIZE_W = 4;
   localparam int BEAT_BYTES = 8;
   localparam int CNT_W = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] chan_kind = 3'd0;
   logic [2:0] opcode = 3'd0;
   logic [SIZE_W-1:0] size = '0;
   logic valid = 1'b0;
   logic ready = 1'b0;
   logic first, last, done;
   logic [CNT_W-1:0] beat_idx;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // behavioural model state
   bit in_burst = 0;
   int burst_len = 0;
   int pos = 0;

   always #2.5 clk = ~clk;

   burst_beat_tracker #(.SIZE_W(SIZE_W), .BEAT_BYTES(BEAT_BYTES)) u0 (
      .clk(clk), .rst_n(rst_n), .chan_kind(chan_kind), .opcode(opcode),
      .size(size), .valid(valid), .ready(ready), .first(first),
      .last(last), .done(done), .beat_idx(beat_idx)
   );

   function automatic bit carries(input int k, input int op);
      if (k == 0 || k == 1) return ((op / 4) % 2) == 0;
      if (k == 2 || k == 3) return (op % 2) == 1;
      return 0;
   endfunction

   function automatic int msg_beats(input int k, input int op, input int sz);
      int b;
      if (!carries(k, op)) return 1;
      b = (1 << sz) / BEAT_BYTES;
      return (b < 1) ? 1 : b;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // drive one cycle, compare against the model, then advance the model
   task automatic step(input string req, input int k, input int op, input int sz,
                       input bit v, input bit r);
      int len;
      bit e_last;
      @(negedge clk);
      chan_kind = 3'(k); opcode = 3'(op); size = SIZE_W'(sz); valid = v; ready = r;
      #1;
      len = in_burst ? burst_len : msg_beats(k, op, sz);
      e_last = (pos == len - 1);
      chk(req, "first", int'(first), int'(!in_burst));
      chk(req, "last", int'(last), int'(e_last));
      chk(req, "done", int'(done), int'(v && r && e_last));
      chk(req, "beat_idx", int'(beat_idx), pos);
      @(posedge clk);
      if (v && r) begin
         if (e_last) begin
            in_burst = 0; pos = 0;
         end else begin
            in_burst = 1; burst_len = len; pos++;
         end
      end
   endtask

   task automatic burst(input string req, input int k, input int op, input int sz);
      int n;
      n = msg_beats(k, op, sz);
      for (int i = 0; i < n; i++) step(req, k, op, sz, 1, 1);
   endtask

   initial begin
      #4000000;
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1", "first", int'(first), 1);
      chk("R1", "done", int'(done), 0);
      chk("R1", "beat_idx", int'(beat_idx), 0);
      rst_n = 1'b1;

      // R2: kind A put, 32 bytes -> 4 beats
      burst("R2", 0, 0, 5);
      // R2: kind A get (bit 2 set) -> single beat despite size 6
      burst("R2", 0, 4, 6);
      // R2: kind B logical, 8 bytes -> 1 beat
      burst("R2", 1, 3, 3);
      // R2: kind A, 128 bytes -> 16 beats
      burst("R2", 0, 2, 7);
      // R3: kind C op 1, 16 bytes -> 2 beats
      burst("R3", 2, 1, 4);
      // R3: kind C op 0 -> single
      burst("R3", 2, 0, 6);
      // R3: kind D op 5, 32 bytes -> 4 beats
      burst("R3", 3, 5, 5);
      // R3: kind D op 4 -> single
      burst("R3", 3, 4, 5);
      // R4: kind E and unused kind 6 -> single regardless of size
      burst("R4", 4, 1, 7);
      burst("R4", 6, 0, 7);
      // R5: data with size below one beat -> 1 beat
      burst("R5", 0, 1, 0);
      burst("R5", 1, 0, 2);

      // R9: stalls inside a 4-beat burst (valid low, ready low)
      step("R9", 0, 0, 5, 1, 1);
      step("R9", 0, 0, 5, 0, 1);
      step("R9", 0, 0, 5, 1, 0);
      step("R8", 0, 0, 5, 1, 1);
      step("R9", 0, 0, 5, 0, 0);
      step("R8", 0, 0, 5, 1, 1);
      step("R7", 0, 0, 5, 1, 1);
      // R9: stall before a burst starts
      step("R9", 3, 5, 5, 1, 0);
      step("R9", 3, 5, 5, 0, 1);

      // R10: fields change mid-burst, count stays at 4
      step("R10", 3, 5, 5, 1, 1);
      step("R10", 4, 0, 0, 1, 1);
      step("R10", 0, 0, 7, 1, 1);
      step("R10", 2, 0, 0, 1, 1);
      // R6/R7: back-to-back singles then a burst
      step("R6", 4, 0, 0, 1, 1);
      step("R7", 4, 0, 0, 1, 1);
      burst("R6", 2, 1, 4);
      step("R1", 0, 0, 0, 0, 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule